// File: doc/BRIEF.md
# Serial-Triggered ADC Sampling Controller

This block turns a serial line into a trigger for one analog-to-digital conversion. Any byte that arrives on the 8N1 receive line starts a conversion. The content of the byte is not used. The block then returns the converter's 8-bit result as one serial byte on the transmit line. A host reads a sample by writing one byte and waiting for the one-byte reply.

The converter is controlled through two active-low signals. While no byte is pending, the write/reset strobe is held low and the converter stays in reset. When a byte has arrived, the block raises its received flag. The strobe is a direct copy of that flag, so the strobe rises with it and the conversion starts. When the converter pulls its interrupt low, the block loads the result into its transmitter, starts the reply and clears the received flag. Clearing the flag puts the converter back into reset.

A byte that comes in while a conversion or a reply is in progress is dropped, and a one-cycle overrun pulse reports the drop. The baud tick runs at sixteen times the line rate. Its divider is derived from the system clock frequency and the 9600 bit/s rate.

Top module: `adc_serial_trigger`

## Requirements
- R1: After reset, `tx` is 1, `adc_wr_n` is 0, `data_rdy` is 0 and `overrun` is 0.
- R2: A frame that has a valid start bit, eight data bits and a stop bit sampled high sets `data_rdy` to 1. This happens at the middle of the stop bit and not before the stop bit begins. `adc_wr_n` then equals `data_rdy`: it stays low while no byte is pending and rises when a byte is accepted.
- R3: The value of the received byte has no effect. The bytes 0x00, 0xFF and any other pattern each start exactly one conversion.
- R4: A low pulse on `rx` that is shorter than half a bit time is rejected as a glitch. It sets no flag, and the receiver still accepts the next real frame.
- R5: A falling edge on `adc_intr_n` while `data_rdy` is 1 clears `data_rdy` on the next clock, so `adc_wr_n` returns low. On the same clock, `adc_data` is loaded into the transmitter.
- R6: The reply is one 8N1 frame: a start bit of 0, the eight bits of `adc_data` with the least significant bit first, and a stop bit of 1. Each bit lasts 16 ticks, and one tick is CLK_HZ/(16*BAUD) clock cycles.
- R7: `tx` idles at 1 whenever no reply is being sent. A falling edge on `adc_intr_n` while no byte is pending starts no transmission.
- R8: A byte that completes while `data_rdy` is 1 or a reply is being sent is discarded. It does not set `data_rdy`, and `overrun` is 1 for exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx | input | 1 | Serial receive line, idles at 1 |
| tx | output | 1 | Serial transmit line, idles at 1 |
| adc_wr_n | output | 1 | Converter write/reset strobe; low holds the converter in reset |
| adc_intr_n | input | 1 | Converter end-of-conversion interrupt, active low |
| adc_data | input | 8 | Conversion result from the converter |
| data_rdy | output | 1 | Received flag: a byte is pending and a conversion is running |
| overrun | output | 1 | One-cycle pulse when an incoming byte is discarded |

## Verification
The hardest case to reach is an overrun during the reply. The middle of the second frame's stop bit has to land inside the short window between the start of the reply and its end. To get there, the bench starts sending the second frame on the same clock on which it sees the reply's start bit. Its stop-bit sample then falls about one bit-half before the reply ends. Overrun during a conversion is reached by having the converter model stretch its conversion time past a whole incoming frame.

// File: rtl/adc_serial_trigger.sv
module adc_serial_trigger #(
  parameter int CLK_HZ = 50_000_000,
  parameter int BAUD   = 9600,
  parameter int OSR    = 16,
  parameter int DW     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx,
  output logic          tx,
  output logic          adc_wr_n,
  input  logic          adc_intr_n,
  input  logic [DW-1:0] adc_data,
  output logic          data_rdy,
  output logic          overrun
);
  localparam int TICK_DIV = CLK_HZ / (BAUD * OSR);
  localparam int TW   = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int SW   = $clog2(OSR);
  localparam int BW   = $clog2(DW + 2);
  localparam int HALF = OSR / 2 - 1;

  typedef enum logic [1:0] {R_IDLE, R_START, R_DATA, R_STOP} rx_st_t;

  logic [TW-1:0] div;
  logic          tick;
  logic          rx_m, rx_s;
  rx_st_t        rx_st;
  logic [SW-1:0] rx_sub;
  logic [BW-1:0] rx_bit;
  logic          rx_done;
  logic          intr_q;
  logic          intr_fall;
  logic          tx_busy;
  logic [DW+1:0] tx_sh;
  logic [SW-1:0] tx_sub;
  logic [BW-1:0] tx_bit;

  assign tick      = (div == TW'(TICK_DIV - 1));
  assign intr_fall = intr_q & ~adc_intr_n;
  assign adc_wr_n  = data_rdy;
  assign tx        = tx_busy ? tx_sh[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    div <= '0;
    else if (tick) div <= '0;
    else           div <= div + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_m   <= 1'b1;
      rx_s   <= 1'b1;
      intr_q <= 1'b1;
    end else begin
      rx_m   <= rx;
      rx_s   <= rx_m;
      intr_q <= adc_intr_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_st   <= R_IDLE;
      rx_sub  <= '0;
      rx_bit  <= '0;
      rx_done <= 1'b0;
    end else begin
      rx_done <= 1'b0;
      case (rx_st)
        R_IDLE: if (!rx_s) begin
          rx_st  <= R_START;
          rx_sub <= '0;
        end
        R_START: if (tick) begin
          if (rx_sub == SW'(HALF)) begin
            rx_sub <= '0;
            rx_bit <= '0;
            rx_st  <= rx_s ? R_IDLE : R_DATA;
          end else begin
            rx_sub <= rx_sub + 1'b1;
          end
        end
        R_DATA: if (tick) begin
          if (rx_sub == SW'(OSR - 1)) begin
            rx_sub <= '0;
            rx_bit <= rx_bit + 1'b1;
            if (rx_bit == BW'(DW - 1)) rx_st <= R_STOP;
          end else begin
            rx_sub <= rx_sub + 1'b1;
          end
        end
        R_STOP: if (tick) begin
          if (rx_sub == SW'(OSR - 1)) begin
            rx_sub  <= '0;
            rx_done <= rx_s;
            rx_st   <= R_IDLE;
          end else begin
            rx_sub <= rx_sub + 1'b1;
          end
        end
        default: rx_st <= R_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_rdy <= 1'b0;
      overrun  <= 1'b0;
      tx_busy  <= 1'b0;
      tx_sh    <= '1;
      tx_sub   <= '0;
      tx_bit   <= '0;
    end else begin
      overrun <= rx_done & (data_rdy | tx_busy);
      if (rx_done && !data_rdy && !tx_busy) begin
        data_rdy <= 1'b1;
      end else if (data_rdy && intr_fall) begin
        data_rdy <= 1'b0;
        tx_busy  <= 1'b1;
        tx_sh    <= {1'b1, adc_data, 1'b0};
        tx_sub   <= '0;
        tx_bit   <= '0;
      end else if (tx_busy && tick) begin
        if (tx_sub == SW'(OSR - 1)) begin
          tx_sub <= '0;
          tx_sh  <= {1'b1, tx_sh[DW+1:1]};
          tx_bit <= tx_bit + 1'b1;
          if (tx_bit == BW'(DW + 1)) tx_busy <= 1'b0;
        end else begin
          tx_sub <= tx_sub + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/adc_serial_trigger_chk.sv
module adc_serial_trigger_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_done,
  input logic data_rdy,
  input logic tx_busy,
  input logic adc_intr_n,
  input logic overrun,
  input logic tx
);
  // R2
  rdy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && !data_rdy && !tx_busy |=> data_rdy);

  // R2
  rdy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_rdy) |-> $past(rx_done));

  // R5
  intr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_rdy && $fell(adc_intr_n) |=> !data_rdy && tx_busy && !tx);

  // R7
  tx_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> $past(data_rdy));

  // R8
  ovr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && (data_rdy || tx_busy) |=> overrun);

  // R8
  ovr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> !overrun);
endmodule

bind adc_serial_trigger adc_serial_trigger_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .data_rdy(data_rdy),
  .tx_busy(tx_busy), .adc_intr_n(adc_intr_n), .overrun(overrun), .tx(tx)
);

// File: tb/tb_adc_serial_trigger.sv
module tb_adc_serial_trigger;
  localparam int BAUD   = 9600;
  localparam int CLK_HZ = BAUD * 16 * 4;
  localparam int BIT    = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic       adc_intr_n = 1'b1;
  logic [7:0] adc_data = 8'h00;
  logic       tx, adc_wr_n, data_rdy, overrun;

  adc_serial_trigger #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) dut (
    .clk(clk), .rst_n(rst_n), .rx(rx), .tx(tx), .adc_wr_n(adc_wr_n),
    .adc_intr_n(adc_intr_n), .adc_data(adc_data), .data_rdy(data_rdy),
    .overrun(overrun)
  );

  always #10 clk = ~clk;

  int         checks = 0;
  int         errors = 0;
  int         ovr_count = 0;
  int         conv_cycles = 100;
  bit         tx_expect_idle = 1'b0;
  logic       ovr_prev = 1'b0;
  logic [7:0] adc_next = 8'h00;
  logic [7:0] exp_q[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_expect_idle) check(tx === 1'b1, "R7 tx idle high", int'(tx), 1);
      if (overrun === 1'b1) begin
        ovr_count++;
        if (ovr_prev === 1'b1) check(1'b0, "R8 overrun longer than one cycle", 1, 0);
      end
      ovr_prev = overrun;
    end
  end

  initial forever begin
    @(posedge adc_wr_n);
    repeat (conv_cycles) @(negedge clk);
    if (adc_wr_n) begin
      adc_data = adc_next;
      exp_q.push_back(adc_next);
      adc_intr_n = 1'b0;
      @(negedge adc_wr_n);
      @(negedge clk);
      adc_intr_n = 1'b1;
    end
  end

  task automatic send_byte(input logic [7:0] v, input bit chk_pre);
    @(negedge clk);
    rx = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = v[i];
      repeat (BIT) @(negedge clk);
    end
    rx = 1'b1;
    if (chk_pre) check(data_rdy === 1'b0, "R2 flag not before stop bit", int'(data_rdy), 0);
    repeat (BIT) @(negedge clk);
  endtask

  task automatic recv_reply();
    logic [7:0] got;
    logic [7:0] exp;
    do @(negedge clk); while (tx !== 1'b0);
    repeat (BIT / 2) @(negedge clk);
    check(tx === 1'b0, "R6 reply start bit", int'(tx), 0);
    for (int i = 0; i < 8; i++) begin
      repeat (BIT) @(negedge clk);
      got[i] = tx;
    end
    repeat (BIT) @(negedge clk);
    check(tx === 1'b1, "R6 reply stop bit", int'(tx), 1);
    if (exp_q.size() == 0) begin
      check(1'b0, "R6 reply without conversion", int'(got), 0);
    end else begin
      exp = exp_q.pop_front();
      check(got === exp, "R6 reply byte LSB first", int'(got), int'(exp));
    end
  endtask

  task automatic do_txn(input logic [7:0] rxv, input logic [7:0] adcv);
    adc_next = adcv;
    send_byte(rxv, 1'b1);
    repeat (8) @(negedge clk);
    check(data_rdy === 1'b1, "R3 any byte value sets flag", int'(data_rdy), 1);
    check(adc_wr_n === 1'b1, "R2 strobe released", int'(adc_wr_n), 1);
    wait (adc_intr_n === 1'b0);
    @(negedge clk);
    check(data_rdy === 1'b0, "R5 interrupt clears flag", int'(data_rdy), 0);
    check(adc_wr_n === 1'b0, "R5 strobe back low", int'(adc_wr_n), 0);
    recv_reply();
    repeat (40) @(negedge clk);
    check(tx === 1'b1, "R7 line idle after reply", int'(tx), 1);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R2 watchdog expired", 1, 0);
    finish_run();
  end

  initial begin
    int o0;
    repeat (5) @(negedge clk);
    check(tx === 1'b1, "R1 reset tx", int'(tx), 1);
    check(adc_wr_n === 1'b0, "R1 reset strobe", int'(adc_wr_n), 0);
    check(data_rdy === 1'b0, "R1 reset flag", int'(data_rdy), 0);
    check(overrun === 1'b0, "R1 reset overrun", int'(overrun), 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);

    tx_expect_idle = 1'b1;
    adc_intr_n = 1'b0;
    repeat (5) @(negedge clk);
    adc_intr_n = 1'b1;
    repeat (300) @(negedge clk);
    check(data_rdy === 1'b0, "R7 idle interrupt ignored", int'(data_rdy), 0);
    tx_expect_idle = 1'b0;

    do_txn(8'h00, 8'hA5);
    do_txn(8'hFF, 8'h3C);
    do_txn(8'h5A, 8'h00);
    do_txn(8'h81, 8'hFF);

    tx_expect_idle = 1'b1;
    rx = 1'b0;
    repeat (12) @(negedge clk);
    rx = 1'b1;
    repeat (700) @(negedge clk);
    check(data_rdy === 1'b0, "R4 glitch rejected", int'(data_rdy), 0);
    check(adc_wr_n === 1'b0, "R4 converter kept in reset", int'(adc_wr_n), 0);
    tx_expect_idle = 1'b0;
    do_txn(8'h12, 8'h01);

    conv_cycles = 2000;
    adc_next = 8'h69;
    o0 = ovr_count;
    send_byte(8'h11, 1'b1);
    repeat (8) @(negedge clk);
    check(data_rdy === 1'b1, "R2 first byte accepted", int'(data_rdy), 1);
    send_byte(8'h22, 1'b0);
    repeat (8) @(negedge clk);
    check(ovr_count == o0 + 1, "R8 overrun during conversion", ovr_count - o0, 1);
    check(data_rdy === 1'b1, "R8 conversion undisturbed", int'(data_rdy), 1);
    wait (adc_intr_n === 1'b0);
    @(negedge clk);
    recv_reply();
    repeat (40) @(negedge clk);
    tx_expect_idle = 1'b1;
    repeat (1500) @(negedge clk);
    check(data_rdy === 1'b0, "R8 dropped byte starts nothing", int'(data_rdy), 0);
    tx_expect_idle = 1'b0;
    conv_cycles = 100;

    adc_next = 8'hC3;
    o0 = ovr_count;
    send_byte(8'h33, 1'b1);
    wait (adc_intr_n === 1'b0);
    fork
      recv_reply();
      begin
        do @(negedge clk); while (tx !== 1'b0);
        send_byte(8'h44, 1'b0);
      end
    join
    repeat (8) @(negedge clk);
    check(ovr_count == o0 + 1, "R8 overrun during reply", ovr_count - o0, 1);
    repeat (40) @(negedge clk);
    tx_expect_idle = 1'b1;
    repeat (1000) @(negedge clk);
    check(data_rdy === 1'b0, "R8 byte during reply discarded", int'(data_rdy), 0);
    check(exp_q.size() == 0, "R8 no extra conversion", exp_q.size(), 0);
    tx_expect_idle = 1'b0;

    finish_run();
  end
endmodule